// File: doc/BRIEF.md
# Banked CPU Program Address Mapper

This block turns a CPU read inside the upper 32 KB program window into a wide program-ROM address. The window is split into four 8 KB pages. Each page draws an 8-bit bank value from a register or a constant. A programmable size mode then trims that value, and the trimmed-off upper bits come from a fill register. A 4-bit outer base sits on top. The result is a 12-bit bank number, and the page offset is appended to it.

Software programs the block in two ways. It can write a 16-entry register file decoded at 0x4100–0x410F. It can also use a selector/data register pair in the 0x8000–0x9FFF range. The translated address is combinational from the register state, the read offset and a board configuration input. A register write therefore shows up on the output right after the clock edge that stores it.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset every register entry reads as zero, so the pages at 0x8000, 0xA000, 0xC000 and 0xE000 map to banks 0x000, 0x000, 0x03E and 0x03F.
- R2: The size mode is entry 11 bits 2:0. Mode 7 gives a bank mask of 0xFF. Modes 0 to 6 give 0x3F shifted right by the mode, so mode 6 gives a mask of zero.
- R3: Bank bits 11:8 equal entry 0 bits 7:4. Bank bits 7:0 equal (entry 10 AND NOT mask) OR (page value AND mask).
- R4: The page value at 0x8000 is entry 7 and at 0xA000 is entry 8. At 0xC000 it is entry 9 when entry 11 bit 6 is set, and 0xFE otherwise. At 0xE000 it is always 0xFF.
- R5: When entry 5 (the selector) has bit 6 set, the pages at 0x8000 and 0xC000 exchange their page values. 0xA000 and 0xE000 are unaffected.
- R6: A write whose address ANDed with 0xE001 equals 0x8000 loads selector bits 7, 6 and 2:0 from the data and keeps bits 5:3. One whose masked address equals 0x8001 stores the data in entry 7 when selector bits 2:0 are 6, and in entry 8 when they are 7.
- R7: These writes leave the output unchanged: an 0x8001-class write while selector bits 2:0 are 0 to 5, any write at 0xA000 or above, and any write below 0x8000 outside 0x4100–0x410F.
- R8: When `swapLowSlots` is high, the 0x8000 page reads entry 8 and the 0xA000 page reads entry 7, which is the entry index XORed with 0xF.
- R9: `romAddr` is {bank[11:0], rdAddr[12:0]}. It changes only through `rdAddr`, `swapLowSlots`, or a register write at the preceding clock edge.
- R10: A write in 0x4100–0x410F stores the whole data byte into entry wrAddr[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swapLowSlots | input | 1 | Board option: exchange the register sources of the first two pages |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| rdAddr | input | 15 | CPU read address bits 14:0 within the 0x8000–0xFFFF window |
| romAddr | output | 25 | Translated program-ROM byte address |

## Verification
The assertions check three things on every cycle. The page offset is passed through unchanged. The output holds steady when no write occurred and the inputs did not move. Writes to ignored address ranges never disturb it, and the reset mapping of the fixed pages holds until the first write. The mask arithmetic, the page-source selection, the selector merge and both swap mechanisms depend on register contents. Only the bench's scenarios can show those: directed sequences, and a random write stream compared against a behavioural model on every clock.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int REG_DATA_W = 8;
  localparam int REG_IDX_W  = 4;
  localparam int REG_COUNT  = 1 << REG_IDX_W;

  // Register file entries this block decodes
  localparam logic [REG_IDX_W-1:0] IDX_OUTER = 4'h0;
  localparam logic [REG_IDX_W-1:0] IDX_CMD   = 4'h5;
  localparam logic [REG_IDX_W-1:0] IDX_PAGEA = 4'h7;
  localparam logic [REG_IDX_W-1:0] IDX_PAGEB = 4'h8;
  localparam logic [REG_IDX_W-1:0] IDX_PAGEC = 4'h9;
  localparam logic [REG_IDX_W-1:0] IDX_FILL  = 4'hA;
  localparam logic [REG_IDX_W-1:0] IDX_MODE  = 4'hB;

  // Selector codes that route the data port to program pages
  localparam logic [2:0] SEL_PAGEA = 3'd6;
  localparam logic [2:0] SEL_PAGEB = 3'd7;

  localparam int CMD_SWAP_BIT  = 6;
  localparam int MODE_SLOT2_BIT = 6;

  // Bits of the selector retained on a selector write
  localparam logic [REG_DATA_W-1:0] CMD_KEEP = 8'h38;

  // Write request from control to datapath
  typedef struct packed {
    logic                  we;
    logic [REG_IDX_W-1:0]  idx;
    logic [REG_DATA_W-1:0] data;
    logic [REG_DATA_W-1:0] keep;
  } reg_wr_t;

endpackage

// File: rtl/prg_map_ctrl.sv
module prg_map_ctrl
  import prg_map_pkg::*;
#(
  parameter int CPU_AW = 16
) (
  input  logic                  wrEn,
  input  logic [CPU_AW-1:0]     wrAddr,
  input  logic [REG_DATA_W-1:0] wrData,
  input  logic [2:0]            cmdSel,
  output reg_wr_t               wrReq
);

  localparam logic [CPU_AW-1:0] FILE_BASE  = CPU_AW'(16'h4100);
  localparam logic [CPU_AW-1:0] PAIR_MASK  = CPU_AW'(16'hE001);
  localparam logic [CPU_AW-1:0] PAIR_CMD   = CPU_AW'(16'h8000);
  localparam logic [CPU_AW-1:0] PAIR_DATA  = CPU_AW'(16'h8001);

  logic fileHit, cmdHit, dataHit;

  assign fileHit = (wrAddr[CPU_AW-1:REG_IDX_W] == FILE_BASE[CPU_AW-1:REG_IDX_W]);
  assign cmdHit  = ((wrAddr & PAIR_MASK) == PAIR_CMD);
  assign dataHit = ((wrAddr & PAIR_MASK) == PAIR_DATA);

  always_comb begin
    wrReq      = '0;
    wrReq.data = wrData;
    if (wrEn) begin
      if (fileHit) begin
        wrReq.we  = 1'b1;
        wrReq.idx = wrAddr[REG_IDX_W-1:0];
      end else if (cmdHit) begin
        wrReq.we   = 1'b1;
        wrReq.idx  = IDX_CMD;
        wrReq.keep = CMD_KEEP;
      end else if (dataHit) begin
        unique case (cmdSel)
          SEL_PAGEA: begin
            wrReq.we  = 1'b1;
            wrReq.idx = IDX_PAGEA;
          end
          SEL_PAGEB: begin
            wrReq.we  = 1'b1;
            wrReq.idx = IDX_PAGEB;
          end
          default: wrReq.we = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/prg_map_datapath.sv
module prg_map_datapath
  import prg_map_pkg::*;
#(
  parameter int OUTER_W = 4,
  parameter int PAGE_W  = 13,
  parameter int WIN_W   = 15
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  reg_wr_t                wrReq,
  input  logic                   swapLowSlots,
  input  logic [WIN_W-1:0]       rdAddr,
  output logic [2:0]             cmdSel,
  output logic [OUTER_W+REG_DATA_W+PAGE_W-1:0] romAddr
);

  localparam int BANK_W   = OUTER_W + REG_DATA_W;
  localparam int SLOT_N   = 4;
  localparam int SLOT_W   = $clog2(SLOT_N);
  localparam logic [REG_DATA_W-1:0] SLOT2_FIXED = 8'hFE;
  localparam logic [REG_DATA_W-1:0] SLOT3_FIXED = 8'hFF;
  localparam logic [REG_DATA_W-1:0] WIDE_MASK   = 8'hFF;
  localparam logic [REG_DATA_W-1:0] BASE_MASK   = 8'h3F;

  logic [REG_DATA_W-1:0] regFile [REG_COUNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (wrReq.we) begin
      regFile[wrReq.idx] <= (regFile[wrReq.idx] & wrReq.keep) |
                            (wrReq.data & ~wrReq.keep);
    end
  end

  assign cmdSel = regFile[IDX_CMD][2:0];

  // Size-mode mask
  logic [2:0]            sizeMode;
  logic [REG_DATA_W-1:0] bankMask;
  assign sizeMode = regFile[IDX_MODE][2:0];
  always_comb begin
    if (sizeMode == 3'd7) bankMask = WIDE_MASK;
    else                  bankMask = BASE_MASK >> sizeMode;
  end

  // Page sources
  logic [REG_IDX_W-1:0]  idxA, idxB;
  logic [REG_DATA_W-1:0] slotVal [SLOT_N];
  assign idxA = IDX_PAGEA ^ {REG_IDX_W{swapLowSlots}};
  assign idxB = IDX_PAGEB ^ {REG_IDX_W{swapLowSlots}};

  always_comb begin
    slotVal[0] = regFile[idxA];
    slotVal[1] = regFile[idxB];
    slotVal[2] = regFile[IDX_MODE][MODE_SLOT2_BIT] ? regFile[IDX_PAGEC] : SLOT2_FIXED;
    slotVal[3] = SLOT3_FIXED;
  end

  // Per-page bank numbers
  logic [OUTER_W-1:0]    outerBase;
  logic [REG_DATA_W-1:0] fillBits;
  logic [BANK_W-1:0]     slotBank [SLOT_N];
  assign outerBase = regFile[IDX_OUTER][REG_DATA_W-1 -: OUTER_W];
  assign fillBits  = regFile[IDX_FILL] & ~bankMask;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    assign slotBank[s] = {outerBase, fillBits | (slotVal[s] & bankMask)};
  end

  // Window to page selection with selector swap
  logic [SLOT_W-1:0] win, slotSel;
  logic              swapHi;
  assign win     = rdAddr[PAGE_W +: SLOT_W];
  assign swapHi  = regFile[IDX_CMD][CMD_SWAP_BIT] & ~win[0];
  assign slotSel = win ^ {swapHi, 1'b0};

  assign romAddr = {slotBank[slotSel], rdAddr[PAGE_W-1:0]};

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int CPU_AW  = 16,
  parameter int OUTER_W = 4,
  parameter int PAGE_W  = 13,
  localparam int WIN_W  = CPU_AW - 1,
  localparam int ROM_AW = OUTER_W + REG_DATA_W + PAGE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  swapLowSlots,
  input  logic                  wrEn,
  input  logic [CPU_AW-1:0]     wrAddr,
  input  logic [REG_DATA_W-1:0] wrData,
  input  logic [WIN_W-1:0]      rdAddr,
  output logic [ROM_AW-1:0]     romAddr
);

  reg_wr_t    wrReq;
  logic [2:0] cmdSel;

  prg_map_ctrl #(.CPU_AW(CPU_AW)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cmdSel (cmdSel),
    .wrReq  (wrReq)
  );

  prg_map_datapath #(.OUTER_W(OUTER_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrReq        (wrReq),
    .swapLowSlots (swapLowSlots),
    .rdAddr       (rdAddr),
    .cmdSel       (cmdSel),
    .romAddr      (romAddr)
  );

endmodule

// File: rtl/prg_map_checker.sv
module prg_map_checker #(
  parameter int CPU_AW = 16,
  parameter int PAGE_W = 13,
  parameter int ROM_AW = 25
) (
  input logic              clk,
  input logic              rstN,
  input logic              swapLowSlots,
  input logic              wrEn,
  input logic [CPU_AW-1:0] wrAddr,
  input logic [CPU_AW-2:0] rdAddr,
  input logic [ROM_AW-1:0] romAddr
);

  localparam int BANK_W = ROM_AW - PAGE_W;

  logic wroteSinceReset;
  logic ignoredWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     wroteSinceReset <= 1'b0;
    else if (wrEn) wroteSinceReset <= 1'b1;
  end

  assign ignoredWr = wrEn &&
                     (wrAddr[CPU_AW-1:4] != 12'h410) &&
                     (wrAddr[CPU_AW-1:CPU_AW-3] != 3'b100);

  // R1: top page maps to the all-ones page value before any write
  assert_reset_top_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!wroteSinceReset && rdAddr[PAGE_W +: 2] == 2'b11) |->
      romAddr[ROM_AW-1:PAGE_W] == BANK_W'(12'h03F));

  // R1: third page maps to the fixed 0xFE value before any write
  assert_reset_third_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!wroteSinceReset && rdAddr[PAGE_W +: 2] == 2'b10) |->
      romAddr[ROM_AW-1:PAGE_W] == BANK_W'(12'h03E));

  // R9: page offset passes straight through
  assert_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    romAddr[PAGE_W-1:0] == rdAddr[PAGE_W-1:0]);

  // R9: no write and steady inputs keep the output steady
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(rdAddr) && $stable(swapLowSlots)) |->
      $stable(romAddr));

  // R7: writes outside decoded ranges never change the mapping
  assert_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ignoredWr) && $stable(rdAddr) && $stable(swapLowSlots)) |->
      $stable(romAddr));

endmodule

bind prg_bank_mapper prg_map_checker #(
  .CPU_AW (CPU_AW),
  .PAGE_W (PAGE_W),
  .ROM_AW (ROM_AW)
) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .swapLowSlots (swapLowSlots),
  .wrEn         (wrEn),
  .wrAddr       (wrAddr),
  .rdAddr       (rdAddr),
  .romAddr      (romAddr)
);

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swapLowSlots = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [14:0] rdAddr = '0;
  logic [24:0] romAddr;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  model [16];

  always #5 clk = ~clk;

  prg_bank_mapper dut (
    .clk          (clk),
    .rstN         (rstN),
    .swapLowSlots (swapLowSlots),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .rdAddr       (rdAddr),
    .romAddr      (romAddr)
  );

  // Behavioural reference of the register state
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) model[i] = 0;
    end else if (wrEn) begin
      int a, d;
      a = int'(wrAddr);
      d = int'(wrData);
      if ((a >> 4) == 'h410) model[a & 15] = d;
      else if ((a & 'hE001) == 'h8000) model[5] = (model[5] & 'h38) | (d & 'hC7);
      else if ((a & 'hE001) == 'h8001) begin
        if ((model[5] & 7) == 6) model[7] = d;
        else if ((model[5] & 7) == 7) model[8] = d;
      end
    end
  end

  function automatic int expRom(int a, bit sw);
    int mode, mask, win, slot, v, bank;
    mode = model[11] & 7;
    mask = (mode == 7) ? 255 : (63 >> mode);
    win  = (a >> 13) & 3;
    slot = win;
    if ((model[5] & 64) != 0) begin
      if (win == 0) slot = 2;
      else if (win == 2) slot = 0;
    end
    case (slot)
      0: v = sw ? model[8] : model[7];
      1: v = sw ? model[7] : model[8];
      2: v = ((model[11] & 64) != 0) ? model[9] : 254;
      default: v = 255;
    endcase
    bank = ((model[0] >> 4) << 8) | (model[10] & ~mask & 255) | (v & mask);
    return (bank << 13) | (a & 'h1FFF);
  endfunction

  // Every-clock comparison against the model (R9, and all others by coverage)
  always @(negedge clk) begin
    if (rstN && !done) begin
      int e;
      e = expRom(int'(rdAddr), swapLowSlots);
      checks++;
      if (romAddr !== 25'(e)) begin
        fails++;
        $display("FAIL R9 model compare rd=%h: actual %h expected %h", rdAddr, romAddr, 25'(e));
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic probe(input string req, input logic [14:0] a, input int exp);
    @(posedge clk); #2;
    rdAddr = a;
    @(negedge clk);
    checks++;
    if (romAddr !== 25'(exp)) begin
      fails++;
      $display("FAIL %s rd=%h: actual %h expected %h", req, a, romAddr, 25'(exp));
    end
  endtask

  task automatic doReset();
    @(posedge clk); #2;
    rstN = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired: actual running expected finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset mapping
    probe("R1", 15'h0000, 'h0);
    probe("R1", 15'h4000, 'h7C000);
    probe("R1", 15'h6000, 'h7E000);

    // R10 and R4: file writes to page entries
    wr(16'h4107, 8'h05);
    wr(16'h4108, 8'h09);
    probe("R4", 15'h0123, 'hA123);
    probe("R4", 15'h2000, 'h12000);

    // R2 wide mask
    wr(16'h410B, 8'h07);
    wr(16'h4107, 8'hC5);
    probe("R2", 15'h0000, 'h18A000);

    // R2 and R3 narrow mask with fill
    wr(16'h410B, 8'h03);
    wr(16'h410A, 8'hAB);
    probe("R2", 15'h0000, 'h15A000);

    // R3 outer base
    wr(16'h4100, 8'h30);
    probe("R3", 15'h0000, 'h75A000);
    probe("R4", 15'h4000, 'h75C000);

    // R4 third page from register
    wr(16'h410B, 8'h43);
    wr(16'h4109, 8'h02);
    probe("R4", 15'h4000, 'h754000);
    probe("R4", 15'h6000, 'h75E000);

    // R5 selector swap
    wr(16'h4105, 8'h40);
    probe("R5", 15'h0000, 'h754000);
    probe("R5", 15'h4000, 'h75A000);
    probe("R5", 15'h2000, 'h752000);

    // R6 selector/data pair
    wr(16'h8000, 8'h06);
    wr(16'h8001, 8'h11);
    probe("R6", 15'h0000, 'h752000);
    wr(16'h9FFE, 8'h47);
    wr(16'h9FFF, 8'h22);
    probe("R6", 15'h2000, 'h754000);
    probe("R6", 15'h4000, 'h752000);

    // R7 ignored writes
    wr(16'h8000, 8'h02);
    wr(16'h8001, 8'h55);
    wr(16'hA000, 8'h01);
    wr(16'hC001, 8'hFF);
    wr(16'hE000, 8'hFF);
    wr(16'h4110, 8'hFF);
    wr(16'h2000, 8'hFF);
    probe("R7", 15'h0000, 'h752000);
    probe("R7", 15'h2000, 'h754000);

    // R8 board swap option
    @(posedge clk); #2 swapLowSlots = 1'b1;
    probe("R8", 15'h0000, 'h754000);
    probe("R8", 15'h2000, 'h752000);
    @(posedge clk); #2 swapLowSlots = 1'b0;

    // R9 offset pass-through at the top of the window
    probe("R9", 15'h7FFF, 'h75FFFF);

    // R2 mode 6 clears the mask
    wr(16'h410B, 8'h06);
    probe("R2", 15'h0000, 'h756000);

    // R1 reset mid-run
    doReset();
    probe("R1", 15'h6000, 'h7E000);
    probe("R1", 15'h2000, 'h0);

    // Random stream checked every clock against the model
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [15:0] a;
      r = int'($urandom);
      case (r & 3)
        0: a = 16'h4100 | 16'((r >> 4) & 15);
        1: a = 16'h8000 | 16'((r >> 4) & 'h1FFF);
        2: a = 16'hA000 | 16'((r >> 4) & 'h5FFF);
        default: a = 16'($urandom);
      endcase
      @(posedge clk); #2;
      wrEn = ((r >> 20) & 1) == 1;
      wrAddr = a;
      wrData = 8'($urandom);
      rdAddr = 15'($urandom);
      if (((r >> 24) & 15) == 0) swapLowSlots = ~swapLowSlots;
    end
    @(posedge clk); #2 wrEn = 1'b0;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule